// File: doc/BRIEF.md
# I2C Two-Stage SCL Clock Generator

This block turns a fast peripheral clock into the bit timing of an I2C controller. A first stage divides the peripheral clock by a programmable factor to produce an internal tick. A second stage counts those ticks to build each SCL period from a fixed part of twenty ticks, plus eight ticks per step of a coarse divider, plus a small compensation term. The compensation term covers the ticks lost to SCL fall time, rise time and internal delay. The block drives an SCL pull-down enable and reports the released-high phase. It also gives a byte shifter two one-cycle strobes: one to launch the next SDA bit in the middle of the low phase, and one to sample SDA in the middle of the high phase.

Both dividers arrive in one packed configuration word. The fine divider sits in the least significant bits, and the coarse divider sits directly above it. The fine divider is two or three bits wide, chosen by a build parameter. Before the first SCL edge, a programmable setup delay separates the first SDA launch from the first SCL rise. An external device may stretch the clock by holding SCL low after the block releases it; the high phase does not begin counting until the line is actually high. The configuration is captured when the block is enabled and stays fixed until it is disabled.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: After reset and while `enable` is low, `scl_pull_low`, `scl_high_phase`, `launch_stb` and `sample_stb` are all 0.
- R2: `div_cfg` is unpacked as fine divider F = `div_cfg[W-1:0]` and coarse divider G = `div_cfg[W+5:W]` (6 bits, 0..63). W is 3 when `WIDE_CDF`=1 and 2 when `WIDE_CDF`=0, so `div_cfg` is 9 or 8 bits wide.
- R3: The internal tick occurs once every F+1 peripheral cycles, and the SCL high phase (`scl_high_phase`=1, no stretching) lasts (10+4·G)·(F+1) cycles.
- R4: The SCL low phase (`scl_pull_low`=1 after the first high phase) lasts (10+4·G+C)·(F+1) cycles, where C = `comp_ticks`. The full period is therefore (20+8·G+C)·(F+1) cycles.
- R5: One cycle after `enable` is seen high, the block pulls SCL low and asserts `launch_stb` for that cycle. `scl_high_phase` rises S+2 cycles after that strobe, where S = `setup_cfg`; S=15 gives 17 cycles.
- R6: `sample_stb` pulses for one cycle in each high phase, (H/2)·(F+1)+F cycles after the phase starts, where H = 10+4·G and "/" truncates.
- R7: `launch_stb` pulses for one cycle in each low phase, (L/2)·(F+1)+F cycles after the phase starts, where L = H+C.
- R8: While `scl_high_phase`=1 and `scl_in` is 0, the high phase stops counting. Both `sample_stb` and the end of the phase are delayed by exactly the number of stretched cycles.
- R9: Changes to `div_cfg`, `comp_ticks` and `setup_cfg` while enabled have no effect on the running waveform. The values present at the next enable are used.
- R10: When `enable` goes low, `scl_pull_low` and `scl_high_phase` are 0 from the next cycle on, and no strobe is produced while `enable` stays low.
- R11: `launch_stb` and `sample_stb` are never asserted in the same cycle, and each high phase contains exactly one `sample_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low returns it to idle |
| div_cfg | input | 6+W | Packed dividers: fine divider in the low W bits, coarse divider above |
| comp_ticks | input | 4 | Extra ticks added to each low phase for rise/fall/internal delay |
| setup_cfg | input | 4 | First-bit setup value; delay is value+2 peripheral cycles |
| scl_in | input | 1 | Sensed SCL line level (synchronous to clk) |
| scl_pull_low | output | 1 | Drive SCL low when 1, release when 0 |
| scl_high_phase | output | 1 | SCL released and in its high phase |
| launch_stb | output | 1 | One-cycle strobe to put the next bit on SDA |
| sample_stb | output | 1 | One-cycle strobe to sample SDA |

## Verification
The hardest situation to reach is clock stretching that lands inside a high phase. Here the prescaler and the phase count must both freeze, and the sample point must move by exactly the held time. The bench models the wired-AND SCL line as the block's release ANDed with an external hold. It raises the hold in the same cycle the high phase is first seen, keeps it for a fixed number of cycles, and then measures the sample and phase-end offsets. A second, narrow-divider instance confirms the packing for the two-bit fine divider. A configuration write made in the middle of a run confirms that the old divider stays in force.

// File: rtl/i2c_scl_clkgen_pkg.sv
package i2c_scl_clkgen_pkg;

   // fixed part of one half period, in internal ticks
   localparam int unsigned HALF_BASE   = 10;
   // coarse divider weight per half period is 4 ticks (shift of 2)
   localparam int unsigned COARSE_SHL  = 2;
   // widest fine divider supported by any variant
   localparam int unsigned FINE_BUS_W  = 3;
   // setup delay = setup value + this bias, in peripheral cycles
   localparam int unsigned SETUP_BIAS  = 2;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_HIGH  = 2'd2,
      PH_LOW   = 2'd3
   } scl_phase_e;

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
   import i2c_scl_clkgen_pkg::*;
#(
   parameter bit          WIDE_CDF = 1'b1,
   parameter int unsigned COARSE_W = 6,
   parameter int unsigned COMP_W   = 4,
   parameter int unsigned SETUP_W  = 4,
   localparam int unsigned FINE_W  = WIDE_CDF ? 3 : 2,
   localparam int unsigned CFG_W   = COARSE_W + FINE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [CFG_W-1:0]      div_cfg_i,
   input  logic [COMP_W-1:0]     comp_i,
   input  logic [SETUP_W-1:0]    setup_i,
   output logic [FINE_BUS_W-1:0] fine_o,
   output logic [COARSE_W-1:0]   coarse_o,
   output logic [COMP_W-1:0]     comp_o,
   output logic [SETUP_W-1:0]    setup_o
);

   logic [FINE_BUS_W-1:0] fine_unpacked;
   logic [COARSE_W-1:0]   coarse_unpacked;

   // field split: fine divider in the low bits, coarse directly above
   generate
      if (WIDE_CDF) begin : g_fine3
         assign fine_unpacked = div_cfg_i[FINE_BUS_W-1:0];
      end else begin : g_fine2
         assign fine_unpacked = {{(FINE_BUS_W-FINE_W){1'b0}}, div_cfg_i[FINE_W-1:0]};
      end
   endgenerate

   assign coarse_unpacked = div_cfg_i[CFG_W-1:FINE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fine_o   <= '0;
         coarse_o <= '0;
         comp_o   <= '0;
         setup_o  <= '0;
      end else if (load_i) begin
         fine_o   <= fine_unpacked;
         coarse_o <= coarse_unpacked;
         comp_o   <= comp_i;
         setup_o  <= setup_i;
      end
   end

   // R9: captured values only move on a load
   assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i) |=> $stable({fine_o, coarse_o, comp_o, setup_o}));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
   import i2c_scl_clkgen_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_i,
   input  logic                  advance_i,
   input  logic [FINE_BUS_W-1:0] fine_i,
   output logic                  tick_o
);

   logic [FINE_BUS_W-1:0] pre_q;
   logic                  wrap;

   assign wrap   = (pre_q == fine_i);
   assign tick_o = run_i && advance_i && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run_i) begin
         pre_q <= '0;
      end else if (advance_i) begin
         pre_q <= wrap ? '0 : pre_q + 1'b1;
      end
   end

   // R3: count never passes the fine divider while running
   assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (pre_q <= fine_i));

   // R8: a stalled prescaler holds its count (or restarts when stopped)
   assert_pre_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !advance_i) |=> ($stable(pre_q) || pre_q == '0));

endmodule

// File: rtl/scl_setup_timer.sv
module scl_setup_timer
   import i2c_scl_clkgen_pkg::*;
#(
   parameter int unsigned SETUP_W = 4,
   localparam int unsigned CNT_W  = $clog2((2**SETUP_W) + SETUP_BIAS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active_i,
   input  logic [SETUP_W-1:0] setup_i,
   output logic               first_o,
   output logic               done_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;

   assign last_cnt = CNT_W'(setup_i) + CNT_W'(SETUP_BIAS - 1);
   assign first_o  = active_i && (cnt_q == '0);
   assign done_o   = active_i && (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R5: setup never runs past its programmed length
   assert_setup_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |-> (cnt_q <= last_cnt));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
   import i2c_scl_clkgen_pkg::*;
#(
   parameter int unsigned COARSE_W = 6,
   parameter int unsigned COMP_W   = 4,
   localparam int unsigned HALF_MAX = HALF_BASE + ((2**COARSE_W - 1) << COARSE_SHL),
   localparam int unsigned LOW_MAX  = HALF_MAX + (2**COMP_W - 1),
   localparam int unsigned PH_W     = $clog2(LOW_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic                scl_in,
   input  logic                tick_i,
   input  logic                setup_first_i,
   input  logic                setup_done_i,
   input  logic [COARSE_W-1:0] coarse_i,
   input  logic [COMP_W-1:0]   comp_i,
   output logic                load_o,
   output logic                setup_active_o,
   output logic                run_o,
   output logic                advance_o,
   output logic                pull_low_o,
   output logic                high_o,
   output logic                launch_o,
   output logic                sample_o
);

   scl_phase_e       state_q;
   logic [PH_W-1:0]  ph_q;
   logic [PH_W-1:0]  half_len;
   logic [PH_W-1:0]  low_len;
   logic             in_high;
   logic             in_low;

   assign half_len = PH_W'(HALF_BASE) + (PH_W'(coarse_i) << COARSE_SHL);
   assign low_len  = half_len + PH_W'(comp_i);

   assign in_high        = (state_q == PH_HIGH);
   assign in_low         = (state_q == PH_LOW);
   assign load_o         = (state_q == PH_IDLE) && en_i;
   assign setup_active_o = (state_q == PH_SETUP);
   assign run_o          = in_high || in_low;
   assign advance_o      = in_low || (in_high && scl_in);
   assign pull_low_o     = (state_q == PH_SETUP) || in_low;
   assign high_o         = in_high;

   assign sample_o = en_i && in_high && tick_i && (ph_q == (half_len >> 1));
   assign launch_o = en_i && (setup_first_i ||
                     (in_low && tick_i && (ph_q == (low_len >> 1))));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         ph_q    <= '0;
      end else if (!en_i) begin
         state_q <= PH_IDLE;
         ph_q    <= '0;
      end else begin
         unique case (state_q)
            PH_IDLE: begin
               state_q <= PH_SETUP;
               ph_q    <= '0;
            end
            PH_SETUP: begin
               if (setup_done_i) begin
                  state_q <= PH_HIGH;
                  ph_q    <= '0;
               end
            end
            PH_HIGH: begin
               if (tick_i) begin
                  if (ph_q == half_len - 1'b1) begin
                     state_q <= PH_LOW;
                     ph_q    <= '0;
                  end else begin
                     ph_q <= ph_q + 1'b1;
                  end
               end
            end
            PH_LOW: begin
               if (tick_i) begin
                  if (ph_q == low_len - 1'b1) begin
                     state_q <= PH_HIGH;
                     ph_q    <= '0;
                  end else begin
                     ph_q <= ph_q + 1'b1;
                  end
               end
            end
            default: begin
               state_q <= PH_IDLE;
               ph_q    <= '0;
            end
         endcase
      end
   end

   // R10: dropping enable releases the line on the next cycle
   assert_release_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i) |=> (!pull_low_o && !high_o));

   // R11: the two strobes are exclusive
   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(launch_o && sample_o));

   // R6: sampling happens only with SCL released
   assert_sample_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> high_o);

   // R7: launching happens only with SCL pulled low
   assert_launch_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      launch_o |-> pull_low_o);

   // R8: a held-low line freezes the high-phase count
   assert_stretch_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_high && !scl_in && en_i) |=> ($stable(ph_q) && high_o));

   // R4: low-phase count stays inside the programmed length
   assert_low_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_low |-> (ph_q < low_len));

endmodule

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen
   import i2c_scl_clkgen_pkg::*;
#(
   parameter bit          WIDE_CDF = 1'b1,
   parameter int unsigned COARSE_W = 6,
   parameter int unsigned COMP_W   = 4,
   parameter int unsigned SETUP_W  = 4,
   localparam int unsigned FINE_W  = WIDE_CDF ? 3 : 2,
   localparam int unsigned CFG_W   = COARSE_W + FINE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [CFG_W-1:0]   div_cfg,
   input  logic [COMP_W-1:0]  comp_ticks,
   input  logic [SETUP_W-1:0] setup_cfg,
   input  logic               scl_in,
   output logic               scl_pull_low,
   output logic               scl_high_phase,
   output logic               launch_stb,
   output logic               sample_stb
);

   // elaboration-time parameter checks
   generate
      if (COARSE_W < 1 || COARSE_W > 8) begin : g_bad_coarse
         $error("COARSE_W must be 1..8");
      end
      if (COMP_W < 1 || COMP_W > 8) begin : g_bad_comp
         $error("COMP_W must be 1..8");
      end
      if (SETUP_W < 1 || SETUP_W > 8) begin : g_bad_setup
         $error("SETUP_W must be 1..8");
      end
   endgenerate

   logic [FINE_BUS_W-1:0] fine_q;
   logic [COARSE_W-1:0]   coarse_q;
   logic [COMP_W-1:0]     comp_q;
   logic [SETUP_W-1:0]    setup_q;
   logic                  load;
   logic                  setup_active;
   logic                  setup_first;
   logic                  setup_done;
   logic                  run;
   logic                  advance;
   logic                  tick;

   scl_cfg_hold #(
      .WIDE_CDF (WIDE_CDF),
      .COARSE_W (COARSE_W),
      .COMP_W   (COMP_W),
      .SETUP_W  (SETUP_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .div_cfg_i (div_cfg),
      .comp_i    (comp_ticks),
      .setup_i   (setup_cfg),
      .fine_o    (fine_q),
      .coarse_o  (coarse_q),
      .comp_o    (comp_q),
      .setup_o   (setup_q)
   );

   scl_prescaler u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .advance_i (advance),
      .fine_i    (fine_q),
      .tick_o    (tick)
   );

   scl_setup_timer #(
      .SETUP_W (SETUP_W)
   ) u_setup (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (setup_active),
      .setup_i  (setup_q),
      .first_o  (setup_first),
      .done_o   (setup_done)
   );

   scl_phase_seq #(
      .COARSE_W (COARSE_W),
      .COMP_W   (COMP_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .en_i           (enable),
      .scl_in         (scl_in),
      .tick_i         (tick),
      .setup_first_i  (setup_first),
      .setup_done_i   (setup_done),
      .coarse_i       (coarse_q),
      .comp_i         (comp_q),
      .load_o         (load),
      .setup_active_o (setup_active),
      .run_o          (run),
      .advance_o      (advance),
      .pull_low_o     (scl_pull_low),
      .high_o         (scl_high_phase),
      .launch_o       (launch_stb),
      .sample_o       (sample_stb)
   );

   // R1: idle outputs while disabled and settled
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && $past(!enable)) |-> (!scl_pull_low && !scl_high_phase && !launch_stb && !sample_stb));

   // R5: enabling from idle starts with the line pulled low and a launch
   assert_first_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load) |=> (!enable || (scl_pull_low && launch_stb)));

endmodule

// File: tb/i2c_scl_clkgen_bench.sv
module i2c_scl_clkgen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [8:0] div_cfg = '0;
   logic [3:0] comp_ticks = '0;
   logic [3:0] setup_cfg = '0;
   logic       ext_hold = 1'b0;
   logic       scl_in;
   logic       scl_pull_low, scl_high_phase, launch_stb, sample_stb;

   logic       en_n = 1'b0;
   logic [7:0] cfg_n = '0;
   logic       scl_in_n;
   logic       pull_n, high_n, launch_n, sample_n;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   // wired-AND SCL line
   assign scl_in   = !scl_pull_low && !ext_hold;
   assign scl_in_n = !pull_n;

   i2c_scl_clkgen u_i2c_scl_clkgen (
      .clk            (clk),
      .rst_n          (rst_n),
      .enable         (enable),
      .div_cfg        (div_cfg),
      .comp_ticks     (comp_ticks),
      .setup_cfg      (setup_cfg),
      .scl_in         (scl_in),
      .scl_pull_low   (scl_pull_low),
      .scl_high_phase (scl_high_phase),
      .launch_stb     (launch_stb),
      .sample_stb     (sample_stb)
   );

   i2c_scl_clkgen #(.WIDE_CDF(1'b0)) u_i2c_scl_clkgen_narrow (
      .clk            (clk),
      .rst_n          (rst_n),
      .enable         (en_n),
      .div_cfg        (cfg_n),
      .comp_ticks     (4'd0),
      .setup_cfg      (4'd0),
      .scl_in         (scl_in_n),
      .scl_pull_low   (pull_n),
      .scl_high_phase (high_n),
      .launch_stb     (launch_n),
      .sample_stb     (sample_n)
   );

   // cfg, comp, setup, setup_cycles, high_cycles, low_cycles, sample_off, launch_off
   localparam int unsigned NV = 5;
   localparam int unsigned VT [0:NV-1][0:7] = '{
      '{  0, 0, 15, 17,  10,  10,   5,   5},
      '{  9, 2,  0,  2,  28,  32,  15,  17},
      '{  7, 1,  3,  5,  80,  88,  47,  47},
      '{ 26, 0,  1,  3,  66,  66,  35,  35},
      '{504, 0,  0,  2, 262, 262, 131, 131}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // measures setup, one high phase, one low phase and strobe offsets
   task automatic run_vec(input int v);
      int stage = 0;
      int tl0 = 0, th1 = 0, ts = 0, tlo = 0, tl1 = 0, th2 = 0;
      int nsamp = 0;
      bit prev_hi = 1'b0;
      @(negedge clk);
      enable     = 1'b0;
      @(negedge clk);
      div_cfg    = 9'(VT[v][0]);
      comp_ticks = 4'(VT[v][1]);
      setup_cfg  = 4'(VT[v][2]);
      enable     = 1'b1;
      for (int k = 0; k < 3000 && stage < 6; k++) begin
         @(negedge clk);
         if (stage == 0 && launch_stb) begin tl0 = k; stage = 1; end
         else if (stage == 1 && scl_high_phase && !prev_hi) begin th1 = k; stage = 2; end
         else if (stage == 4 && launch_stb) begin tl1 = k; stage = 5; end
         else if (stage == 5 && scl_high_phase && !prev_hi) begin th2 = k; stage = 6; end
         if ((stage == 2 || stage == 3) && sample_stb) begin
            nsamp++;
            if (stage == 2) begin ts = k; stage = 3; end
         end
         if (stage == 3 && !scl_high_phase && prev_hi) begin tlo = k; stage = 4; end
         prev_hi = scl_high_phase;
      end
      chk(stage == 6, "R3 waveform completes", stage, 6);
      chk(th1 - tl0 == int'(VT[v][3]), "R5 setup delay", th1 - tl0, VT[v][3]);
      chk(tlo - th1 == int'(VT[v][4]), "R3 high length", tlo - th1, VT[v][4]);
      chk(th2 - tlo == int'(VT[v][5]), "R4 low length", th2 - tlo, VT[v][5]);
      chk(ts - th1 == int'(VT[v][6]), "R6 sample offset", ts - th1, VT[v][6]);
      chk(tl1 - tlo == int'(VT[v][7]), "R7 launch offset", tl1 - tlo, VT[v][7]);
      chk(nsamp == 1, "R11 one sample per high", nsamp, 1);
      enable = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int t0;
      int hcnt;
      int nstb;
      bit bad;
      // R1: outputs quiet during and after reset
      repeat (3) @(negedge clk);
      chk(!scl_pull_low && !scl_high_phase && !launch_stb && !sample_stb,
          "R1 in reset", {scl_pull_low, scl_high_phase, launch_stb, sample_stb}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!scl_pull_low && !scl_high_phase && !launch_stb && !sample_stb,
          "R1 disabled idle", {scl_pull_low, scl_high_phase, launch_stb, sample_stb}, 0);

      // vector table (R2 packing, R3..R7, R11)
      for (int v = 0; v < NV; v++) run_vec(v);

      // R8: stretch the first high phase by 6 cycles (cfg 0: H=10, F=0)
      @(negedge clk);
      div_cfg = '0; comp_ticks = '0; setup_cfg = '0; enable = 1'b1;
      while (!scl_high_phase) @(negedge clk);
      ext_hold = 1'b1;
      t0 = 0; bad = 1'b0;
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         if (k == 6) ext_hold = 1'b0;
         if (ext_hold && (sample_stb || !scl_high_phase)) bad = 1'b1;
         if (sample_stb && t0 == 0) t0 = k;
         if (!scl_high_phase && hcnt == 0 && !ext_hold) begin hcnt = k; break; end
      end
      chk(!bad, "R8 frozen while held", bad, 0);
      chk(t0 == 11, "R8 sample delayed", t0, 11);
      chk(hcnt == 16, "R8 high phase extended", hcnt, 16);

      // R9: config written mid-run is ignored
      while (!scl_high_phase) @(negedge clk);
      div_cfg = 9'd9; comp_ticks = 4'd5; setup_cfg = 4'd9;
      while (scl_high_phase) @(negedge clk);
      while (!scl_high_phase) @(negedge clk);
      hcnt = 0;
      while (scl_high_phase) begin hcnt++; @(negedge clk); end
      chk(hcnt == 10, "R9 high length unchanged", hcnt, 10);
      hcnt = 0;
      while (!scl_high_phase) begin hcnt++; @(negedge clk); end
      chk(hcnt == 10, "R9 low length unchanged", hcnt, 10);

      // R10: drop enable during high phase
      enable = 1'b0;
      @(negedge clk);
      chk(!scl_pull_low && !scl_high_phase, "R10 released next cycle",
          {scl_pull_low, scl_high_phase}, 0);
      nstb = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (launch_stb || sample_stb || scl_pull_low || scl_high_phase) nstb++;
      end
      chk(nstb == 0, "R10 quiet while disabled", nstb, 0);

      // R9: new values apply at the next enable (G=1,F=1: high 28)
      div_cfg = 9'd9; comp_ticks = 4'd2; setup_cfg = 4'd0;
      enable = 1'b1;
      while (!scl_high_phase) @(negedge clk);
      hcnt = 0;
      while (scl_high_phase) begin hcnt++; @(negedge clk); end
      chk(hcnt == 28, "R9 next enable uses new cfg", hcnt, 28);
      enable = 1'b0;

      // R2: two-bit fine field, cfg 8'b000001_11 -> F=3, G=1 -> high 56
      @(negedge clk);
      cfg_n = 8'd7; en_n = 1'b1;
      while (!high_n) @(negedge clk);
      hcnt = 0;
      while (high_n) begin hcnt++; @(negedge clk); end
      chk(hcnt == 56, "R2 narrow packing high length", hcnt, 56);
      en_n = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule